// File: doc/BRIEF.md
# Chained-Descriptor DMA Byte-Order Converter

This block is the data path of a DMA engine. Software builds a linked list of descriptors in memory and gives the engine the address of the first one. For each descriptor the engine reads the source block one 64-bit word at a time. It passes each word through a byte-lane permutation network and writes the result to the destination. The descriptor's own mode field selects the permutation. The engine then follows the descriptor's link to the next entry. Blocks that hold text, halfwords, words or doublewords can therefore sit in one chain, each converted in its own way, and nothing is written to the engine between them.

Memory is reached through one simple request interface for reads and one for writes. The engine keeps at most one request outstanding. A block may have any byte length. The last word of a block carries byte enables so that memory past the end of the block is not disturbed. If a block's length does not divide into whole elements, the incomplete element at the tail is copied as it is, and that descriptor is flagged. When the descriptor marked as the last one in the chain has completed, the engine pulses `done` and presents a status word.

Top module: `dma_swap_engine`

## Requirements
- R1: A rising `start` while idle loads the chain pointer from `start_addr`. Each descriptor is two 64-bit words at the pointer. Word 0 holds the source address in bits [31:0] and the destination address in bits [63:32]. Word 1 holds the byte length in [15:0], the swap mode in [17:16], the end-of-chain flag in [18] and the next-descriptor address in [63:32]. The engine processes descriptors in list order until one with the end flag set has completed.
- R2: Mode 00 copies every byte to the same lane. Lane i is bits [8i+7:8i] of a data word.
- R3: Mode 01 writes input lane i^1 to output lane i, which exchanges the bytes of each halfword.
- R4: Mode 10 writes input lane i^3 to output lane i, which reverses all four bytes of each 32-bit word. This differs from two halfword exchanges.
- R5: Mode 11 writes input lane i^7 to output lane i, which reverses all eight bytes.
- R6: A block of L bytes is moved in ceil(L/8) beats. Every beat except the last has `wr_be` = 8'hFF. The last beat enables only its low L-8*(beats-1) lanes. A length of 0 writes nothing.
- R7: When a nonzero mode is set and L is not a multiple of the element size (2, 4 or 8 bytes), the incomplete trailing element is written unswapped. `desc_err` is then high together with that descriptor's one-cycle `desc_done` pulse. Otherwise `desc_err` stays low.
- R8: After the end-of-chain descriptor, `done` pulses for one cycle and `busy` falls on the next cycle. `status[7:0]` gives the number of descriptors completed in the chain, and `status[15:8]` gives how many of them were flagged under R7.
- R9: A read request holds `rd_req` and `rd_addr` until the cycle in which `rd_rvalid` returns data. A write request holds `wr_req`, `wr_addr`, `wr_data` and `wr_be` until `wr_ack`. `rd_req` and `wr_req` are never high together.
- R10: The low three bits of the chain start, source and destination addresses are ignored. Every access goes to an 8-byte aligned address.
- R11: `start` has no effect while `busy` is high. While the engine is idle it issues no memory request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking a chain (sampled while idle) |
| start_addr | input | 32 | Address of the first descriptor |
| busy | output | 1 | Engine is working on a chain |
| done | output | 1 | One-cycle pulse after the end-of-chain descriptor |
| status | output | 16 | {flagged count, completed count} of the last chain |
| desc_done | output | 1 | One-cycle pulse as each descriptor completes |
| desc_err | output | 1 | Length/element mismatch flag, valid with desc_done |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read byte address, 8-byte aligned |
| rd_rvalid | input | 1 | Read data returned, request accepted |
| rd_rdata | input | 64 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write byte address, 8-byte aligned |
| wr_data | output | 64 | Write data after lane permutation |
| wr_be | output | 8 | Per-lane write enables |
| wr_ack | input | 1 | Write accepted |

## Verification
The hardest situation to reach from the ports is a final beat that holds both complete and incomplete elements, with the mode changing from one chained descriptor to the next. One example is a 13-byte block in 32-bit mode followed directly by a 1-byte block in 64-bit mode. A directed chain lines up exactly these lengths next to zero-length and exact-multiple blocks, with misaligned addresses and a stray `start` during the run. Randomized chains then mix lengths from 0 to 200 with all four modes, while the memory model answers after random delays. Every destination slot, including the guard bytes past each block's end, is compared with a byte-by-byte model.

// File: rtl/dma_swap_pkg.sv
package dma_swap_pkg;

  localparam int LANES     = 8;
  localparam int LANE_IDX  = $clog2(LANES);
  localparam int NB_W      = LANE_IDX + 1;
  localparam int LEN_W     = 16;
  localparam int MODE_LSB  = 16;
  localparam int LAST_BIT  = 18;
  localparam int LINK_LSB  = 32;
  localparam int DST_LSB   = 32;

  typedef enum logic [1:0] {
    SWAP_NONE = 2'b00,
    SWAP_H16  = 2'b01,
    SWAP_W32  = 2'b10,
    SWAP_D64  = 2'b11
  } swap_mode_e;

  // XOR applied to a lane index to find its partner inside one element
  function automatic logic [LANE_IDX-1:0] lane_xor(input swap_mode_e m);
    case (m)
      SWAP_H16: return LANE_IDX'(1);
      SWAP_W32: return LANE_IDX'(3);
      SWAP_D64: return LANE_IDX'(7);
      default:  return LANE_IDX'(0);
    endcase
  endfunction

  // Low n lanes enabled
  function automatic logic [LANES-1:0] tail_enables(input logic [NB_W-1:0] n);
    logic [LANES:0] one_hot;
    one_hot = (LANES+1)'(1) << n;
    return LANES'(one_hot - (LANES+1)'(1));
  endfunction

  // Length leaves an incomplete element for the chosen mode
  function automatic logic len_misfit(input logic [LEN_W-1:0] len, input swap_mode_e m);
    return (len & LEN_W'(lane_xor(m))) != '0;
  endfunction

endpackage

// File: rtl/dma_lane_swap_net.sv
module dma_lane_swap_net
  import dma_swap_pkg::*;
#(
  parameter int NLANES = LANES
) (
  input  logic [8*NLANES-1:0]        din,
  input  swap_mode_e                 mode,
  input  logic [$clog2(NLANES):0]    valid_bytes,
  output logic [8*NLANES-1:0]        dout
);
  localparam int IW = $clog2(NLANES);

  logic [IW-1:0] xr;
  assign xr = IW'(lane_xor(mode));

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic [IW-1:0] partner;
    logic [IW:0]   elem_last;
    logic          whole;
    assign partner   = IW'(i) ^ xr;
    assign elem_last = {1'b0, IW'(i) | xr};
    // element is complete when its highest lane lies inside the valid bytes
    assign whole     = elem_last < valid_bytes;
    assign dout[8*i +: 8] = whole ? din[{partner, 3'b000} +: 8] : din[8*i +: 8];
  end

endmodule

// File: rtl/dma_desc_latch.sv
module dma_desc_latch
  import dma_swap_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      word,
  input  logic             cap_addr,
  input  logic             cap_ctrl,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [LEN_W-1:0] len_o,
  output swap_mode_e       mode_o,
  output logic             last_o,
  output logic [AW-1:0]    next_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_o  <= '0;
      dst_o  <= '0;
      len_o  <= '0;
      mode_o <= SWAP_NONE;
      last_o <= 1'b0;
      next_o <= '0;
    end else begin
      if (cap_addr) begin
        src_o <= word[AW-1:0];
        dst_o <= word[DST_LSB +: AW];
      end
      if (cap_ctrl) begin
        len_o  <= word[LEN_W-1:0];
        mode_o <= swap_mode_e'(word[MODE_LSB +: 2]);
        last_o <= word[LAST_BIT];
        next_o <= word[LINK_LSB +: AW];
      end
    end
  end
endmodule

// File: rtl/dma_beat_tracker.sv
module dma_beat_tracker
  import dma_swap_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    src_i,
  input  logic [AW-1:0]    dst_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [NB_W-1:0]  nbytes_o,
  output logic             last_o
);
  logic [LEN_W-1:0] remain;

  assign nbytes_o = (remain >= LEN_W'(LANES)) ? NB_W'(LANES) : NB_W'(remain);
  assign last_o   = remain <= LEN_W'(LANES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      src_o  <= '0;
      dst_o  <= '0;
    end else if (load) begin
      remain <= len_i;
      src_o  <= {src_i[AW-1:LANE_IDX], LANE_IDX'(0)};
      dst_o  <= {dst_i[AW-1:LANE_IDX], LANE_IDX'(0)};
    end else if (step) begin
      remain <= remain - LEN_W'(nbytes_o);
      src_o  <= src_o + AW'(LANES);
      dst_o  <= dst_o + AW'(LANES);
    end
  end
endmodule

// File: rtl/dma_swap_engine.sv
module dma_swap_engine
  import dma_swap_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  output logic              busy,
  output logic              done,
  output logic [2*CW-1:0]   status,
  output logic              desc_done,
  output logic              desc_err,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_rvalid,
  input  logic [8*LANES-1:0] rd_rdata,
  output logic              wr_req,
  output logic [AW-1:0]     wr_addr,
  output logic [8*LANES-1:0] wr_data,
  output logic [LANES-1:0]  wr_be,
  input  logic              wr_ack
);
  localparam int DW = 8 * LANES;

  typedef enum logic [2:0] {
    S_IDLE, S_DESC0, S_DESC1, S_READ, S_WRITE, S_CLOSE, S_FINISH
  } state_e;

  state_e state;

  logic [AW-1:0]     desc_ptr;
  logic [DW-1:0]     beat_q;
  logic [CW-1:0]     desc_cnt, err_cnt;

  // named events for the checker
  logic rd_fire, wr_fire, blk_err, chain_start;

  logic [AW-1:0]     d_src, d_dst, d_next;
  logic [LEN_W-1:0]  d_len;
  swap_mode_e        d_mode;
  logic              d_last;

  logic [AW-1:0]     t_src, t_dst;
  logic [NB_W-1:0]   t_nbytes;
  logic              t_last;
  logic              cap_ctrl;

  assign rd_fire     = rd_req && rd_rvalid;
  assign wr_fire     = wr_req && wr_ack;
  assign chain_start = (state == S_IDLE) && start;
  assign cap_ctrl    = (state == S_DESC1) && rd_fire;
  assign blk_err     = len_misfit(d_len, d_mode);

  dma_desc_latch #(.AW(AW)) u_desc (
    .clk      (clk),
    .rst_n    (rst_n),
    .word     (rd_rdata),
    .cap_addr ((state == S_DESC0) && rd_fire),
    .cap_ctrl (cap_ctrl),
    .src_o    (d_src),
    .dst_o    (d_dst),
    .len_o    (d_len),
    .mode_o   (d_mode),
    .last_o   (d_last),
    .next_o   (d_next)
  );

  dma_beat_tracker #(.AW(AW)) u_beats (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cap_ctrl),
    .src_i    (d_src),
    .dst_i    (d_dst),
    .len_i    (rd_rdata[LEN_W-1:0]),
    .step     ((state == S_WRITE) && wr_fire),
    .src_o    (t_src),
    .dst_o    (t_dst),
    .nbytes_o (t_nbytes),
    .last_o   (t_last)
  );

  dma_lane_swap_net #(.NLANES(LANES)) u_swap (
    .din         (beat_q),
    .mode        (d_mode),
    .valid_bytes (t_nbytes),
    .dout        (wr_data)
  );

  always_comb begin
    rd_req  = 1'b0;
    rd_addr = '0;
    case (state)
      S_DESC0: begin rd_req = 1'b1; rd_addr = desc_ptr; end
      S_DESC1: begin rd_req = 1'b1; rd_addr = desc_ptr + AW'(LANES); end
      S_READ:  begin rd_req = 1'b1; rd_addr = t_src; end
      default: ;
    endcase
  end

  assign wr_req    = (state == S_WRITE);
  assign wr_addr   = wr_req ? t_dst : '0;
  assign wr_be     = wr_req ? tail_enables(t_nbytes) : '0;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FINISH);
  assign desc_done = (state == S_CLOSE);
  assign desc_err  = desc_done && blk_err;
  assign status    = {err_cnt, desc_cnt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      desc_ptr <= '0;
      beat_q   <= '0;
      desc_cnt <= '0;
      err_cnt  <= '0;
    end else begin
      case (state)
        S_IDLE: if (chain_start) begin
          desc_ptr <= {start_addr[AW-1:LANE_IDX], LANE_IDX'(0)};
          desc_cnt <= '0;
          err_cnt  <= '0;
          state    <= S_DESC0;
        end
        S_DESC0: if (rd_fire) state <= S_DESC1;
        S_DESC1: if (rd_fire)
          state <= (rd_rdata[LEN_W-1:0] == '0) ? S_CLOSE : S_READ;
        S_READ: if (rd_fire) begin
          beat_q <= rd_rdata;
          state  <= S_WRITE;
        end
        S_WRITE: if (wr_fire) state <= t_last ? S_CLOSE : S_READ;
        S_CLOSE: begin
          desc_cnt <= desc_cnt + CW'(1);
          if (blk_err) err_cnt <= err_cnt + CW'(1);
          if (d_last) state <= S_FINISH;
          else begin
            desc_ptr <= {d_next[AW-1:LANE_IDX], LANE_IDX'(0)};
            state    <= S_DESC0;
          end
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_swap_engine_chk.sv
module dma_swap_engine_chk
  import dma_swap_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              desc_done,
  input logic              desc_err,
  input logic              rd_req,
  input logic [AW-1:0]     rd_addr,
  input logic              rd_rvalid,
  input logic              wr_req,
  input logic [AW-1:0]     wr_addr,
  input logic [8*LANES-1:0] wr_data,
  input logic [LANES-1:0]  wr_be,
  input logic              wr_ack,
  input logic              chain_start
);
  assert_one_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_rvalid) |=> (rd_req && $stable(rd_addr)));

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));

  assert_be_contig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_be != '0) && ((LANES'(wr_be + LANES'(1)) & wr_be) == '0));

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |-> desc_done);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req |-> rd_addr[LANE_IDX-1:0] == '0) and (wr_req |-> wr_addr[LANE_IDX-1:0] == '0));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !wr_req));

  assert_start_goes_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    chain_start |=> busy);

endmodule

bind dma_swap_engine dma_swap_engine_chk #(.AW(AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .desc_done   (desc_done),
  .desc_err    (desc_err),
  .rd_req      (rd_req),
  .rd_addr     (rd_addr),
  .rd_rvalid   (rd_rvalid),
  .wr_req      (wr_req),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .wr_be       (wr_be),
  .wr_ack      (wr_ack),
  .chain_start (chain_start)
);

// File: tb/dma_swap_engine_tb_top.sv
module dma_swap_engine_tb_top;
  localparam int DESC0 = 32'h100;
  localparam int SRC0  = 32'h800;
  localparam int DST0  = 32'h1000;
  localparam int SLOT  = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        busy, done, desc_done, desc_err;
  logic [15:0] status;
  logic        rd_req, wr_req;
  logic [31:0] rd_addr, wr_addr;
  logic        rd_rvalid = 1'b0;
  logic [63:0] rd_rdata = '0;
  logic [63:0] wr_data;
  logic [7:0]  wr_be;
  logic        wr_ack = 1'b0;

  always #2 clk = ~clk;

  dma_swap_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy), .done(done), .status(status),
    .desc_done(desc_done), .desc_err(desc_err),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wr_ack(wr_ack)
  );

  logic [63:0] mem [0:1023];
  int n_checks = 0, n_fail = 0;
  int seen = 0, done_cnt = 0;
  logic got_err [0:15];
  int nd;
  int t_len [0:7];
  int t_mode [0:7];
  int t_soff [0:7];
  int t_doff [0:7];

  function automatic logic [7:0] rdb(input int a);
    return mem[a >> 3][8*(a & 7) +: 8];
  endfunction

  // expected destination byte k of a block built from whole/partial elements
  function automatic logic [7:0] exp_byte(input int src, input int k, input int len, input int mode);
    int s, e0;
    s  = 1 << mode;
    e0 = (k / s) * s;
    if (e0 + s <= len) return rdb(src + e0 + (s - 1 - (k % s)));
    return rdb(src + k);
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic build_chain();
    for (int i = 0; i < nd; i++) begin
      int s, d, nx;
      s  = SRC0 + i*SLOT + t_soff[i];
      d  = DST0 + i*SLOT + t_doff[i];
      nx = DESC0 + 16*(i+1);
      mem[(DESC0 + 16*i) >> 3]       = {d[31:0], s[31:0]};
      mem[((DESC0 + 16*i) >> 3) + 1] = {nx[31:0], 13'd0, (i == nd-1), t_mode[i][1:0], t_len[i][15:0]};
      for (int w = 0; w < SLOT/8; w++) begin
        mem[((SRC0 + i*SLOT) >> 3) + w] = {$urandom, $urandom};
        mem[((DST0 + i*SLOT) >> 3) + w] = {8{8'hA5}};
      end
    end
  endtask

  task automatic run_chain(input int low_bits, input bit poke);
    int lim, n_err;
    seen = 0; done_cnt = 0;
    @(negedge clk); start = 1'b1; start_addr = DESC0 + low_bits;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1'b1; start_addr = 32'h40;   // R11: ignored while busy
      @(negedge clk); start = 1'b0;
    end
    lim = 0;
    while (done_cnt == 0 && lim < 20000) begin @(negedge clk); lim++; end
    if (done_cnt == 0) begin
      check(1'b0, "R8", "watchdog expired", 0, 1);
      rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
      return;
    end
    repeat (3) @(negedge clk);
    check(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    check(!busy, "R8", "busy after done", busy, 0);
    check(seen == nd, "R1", "descriptors completed", seen, nd);
    n_err = 0;
    for (int i = 0; i < nd; i++) begin
      int bad, src, dst;
      bit want_err;
      logic [7:0] e, a;
      src = SRC0 + i*SLOT; dst = DST0 + i*SLOT;
      want_err = (t_mode[i] != 0) && (t_len[i] % (1 << t_mode[i]) != 0);
      if (want_err) n_err++;
      bad = -1;
      for (int k = 0; k < SLOT; k++) begin
        e = (k < t_len[i]) ? exp_byte(src, k, t_len[i], t_mode[i]) : 8'hA5;
        a = rdb(dst + k);
        if (a != e && bad < 0) bad = k;
      end
      if (bad < 0) check(1'b1, mode_tag(t_mode[i]), "block data", 0, 0);
      else check(1'b0, (bad >= t_len[i]) ? "R6" : (want_err ? "R7" : mode_tag(t_mode[i])),
                 $sformatf("desc %0d byte %0d len %0d mode %0d", i, bad, t_len[i], t_mode[i]),
                 rdb(dst + bad),
                 (bad < t_len[i]) ? exp_byte(src, bad, t_len[i], t_mode[i]) : 8'hA5);
      if (i < seen) check(got_err[i] == want_err, "R7", $sformatf("desc_err desc %0d", i), got_err[i], want_err);
    end
    check(status == {n_err[7:0], nd[7:0]}, "R8", "status word", status, {n_err[7:0], nd[7:0]});
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int w = 0; w < 1024; w++) mem[w] = '0;
    fork
      forever begin
        @(negedge clk);
        if (!rst_n) begin
          rd_rvalid = 1'b0; wr_ack = 1'b0;
        end else begin
          if (desc_done) begin
            if (seen < 16) got_err[seen] = desc_err;
            seen++;
          end
          if (done) done_cnt++;
          if (rd_rvalid) rd_rvalid = 1'b0;
          else if (rd_req && ($urandom % 4 != 0)) begin
            rd_rdata  = mem[rd_addr[12:3]];
            rd_rvalid = 1'b1;
          end
          if (wr_ack) wr_ack = 1'b0;
          else if (wr_req && ($urandom % 4 != 0)) begin
            for (int b = 0; b < 8; b++)
              if (wr_be[b]) mem[wr_addr[12:3]][8*b +: 8] = wr_data[8*b +: 8];
            wr_ack = 1'b1;
          end
        end
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !rd_req && !wr_req && status == 0, "R11", "reset state",
          {busy, done, rd_req, wr_req, status}, 0);

    // directed: one block per mode, full elements (R1..R5)
    nd = 4;
    for (int i = 0; i < 4; i++) begin
      t_len[i] = 64; t_mode[i] = i; t_soff[i] = 0; t_doff[i] = 0;
    end
    build_chain();
    run_chain(0, 1'b0);

    // directed: odd lengths, partial elements, zero length, low address bits (R6, R7, R10, R11)
    nd = 6;
    t_len[0] = 13; t_mode[0] = 2;
    t_len[1] = 1;  t_mode[1] = 3;
    t_len[2] = 0;  t_mode[2] = 1;
    t_len[3] = 7;  t_mode[3] = 0;
    t_len[4] = 9;  t_mode[4] = 1;
    t_len[5] = 24; t_mode[5] = 3;
    for (int i = 0; i < 6; i++) begin t_soff[i] = 5; t_doff[i] = 3; end
    build_chain();
    run_chain(6, 1'b1);

    // random chains
    for (int c = 0; c < 14; c++) begin
      nd = 1 + ($urandom % 6);
      for (int i = 0; i < nd; i++) begin
        t_len[i]  = $urandom % 201;
        t_mode[i] = $urandom % 4;
        t_soff[i] = $urandom % 8;
        t_doff[i] = $urandom % 8;
      end
      build_chain();
      run_chain($urandom % 8, c[0]);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule